// File: doc/BRIEF.md
# CCD Horizontal Line Readout Timing Generator

This block sequences the horizontal output register of a full-frame CCD for one line. It runs from a clock at six times the pixel rate, so each pixel period splits into six sub-ticks numbered 0 to 5. From these sub-ticks it builds three 50% register clocks, each 120 degrees apart. It also drives a summing-gate clock, a one-sub-tick reset-gate pulse and a shift enable that stops the register clocks outside the pixel shift window.

For every pixel period the block also reports what kind of sample the output amplifier is producing. The classes are dummy cell, black reference, timing (overscan) or active image. It raises a clamp window over the trailing black pixels and a strobe at the sub-tick where a downstream sampler should capture the sample.

A line is 3487 pixel periods long. The first 3127 periods shift pixels out. The last 360 periods keep the register clocks stopped so that a vertical transfer can take place. Horizontal binning merges neighbouring pixel pairs at the summing gate.

Top module: `ccd_hline_timing`

## Requirements
- R1: While `rst` is high, and after it is released with no line started, every output is 0. `pix_tag` then reads 0, which is the code for "no pixel".
- R2: A `line_start` sampled high while idle starts a line. In the first cycle after that clock edge the block is at pixel period 0, sub-tick 0. The line lasts 3487 x 6 cycles. `line_done` is high for exactly one cycle, on sub-tick 5 of period 3486, and the block is idle in the cycle after it.
- R3: A `line_start` that arrives while a line is running has no effect on any output.
- R4: `shift_en` is high throughout periods 0 to 3126 and low in periods 3127 to 3486. While it is low, `reg_c1`, `reg_c2`, `reg_c3`, `sum_gate` and `reset_gate` are all 0.
- R5: During shifting, `reg_c1` is high on sub-ticks 0 to 2, `reg_c2` on sub-ticks 2 to 4, and `reg_c3` on sub-ticks 4, 5 and 0.
- R6: Without binning, `reset_gate` is high only on sub-tick 0 of each shifted period, for one cycle.
- R7: Without binning, `sum_gate` is high on sub-ticks 0 to 2 of each shifted period.
- R8: `pix_tag` classifies each shifted period p. Periods 0 to 6 are dummy (code 1). Periods 7 to 26 and 3107 to 3126 are black (code 2). Periods 27 to 30 and 3103 to 3106 are timing (code 3). Periods 31 to 3102 are active (code 4). Every other cycle reads 0.
- R9: `clamp_win` is high exactly during periods 3107 to 3126.
- R10: Without binning, `sample_valid` is high on sub-tick 5 of every shifted period, which gives 3072 strobes on active-tagged periods per line.
- R11: With binning, pixels pair up as (even, odd) period indices. `sum_gate` stays high through the whole even period and sub-ticks 0 to 2 of the odd one. `reset_gate` fires only on sub-tick 0 of even periods. `sample_valid` fires only on sub-tick 5 of odd periods, which gives 1536 active strobes per line.
- R12: `bin_en` is sampled only at line start. Changing it during a line has no effect on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at six times the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Strobe that starts one line when idle |
| bin_en | input | 1 | Horizontal pair binning select, latched at line start |
| reg_c1 | output | 1 | Register clock phase 1 |
| reg_c2 | output | 1 | Register clock phase 2 |
| reg_c3 | output | 1 | Register clock phase 3 |
| sum_gate | output | 1 | Summing-gate clock |
| reset_gate | output | 1 | Sense-node reset pulse |
| shift_en | output | 1 | High while the register clocks run |
| pix_tag | output | 3 | Class of the current pixel period |
| clamp_win | output | 1 | Black-level clamp window |
| sample_valid | output | 1 | Sample capture strobe |
| line_done | output | 1 | Pulse on the last cycle of the line |

## Verification
The assertions assume that reset is high from time zero and that `line_start` and `bin_en` are synchronous to `clk`. They place no limit on when or how often `line_start` arrives. The bench changes every input on the falling edge, and it fires extra `line_start` strobes and flips `bin_en` in the middle of running lines. Every output is decoded from registered state only, so the bench can sample between edges without any combinational path from the inputs.

// File: rtl/ccd_hline_pkg.sv
package ccd_hline_pkg;

    // sub-ticks per pixel period; the phase plan relies on six
    localparam int SUBS = 6;
    localparam int SUB_W = 3;

    localparam int DEF_DUMMY  = 7;
    localparam int DEF_BLACK  = 20;
    localparam int DEF_TIMING = 4;
    localparam int DEF_ACTIVE = 3072;
    localparam int DEF_STOP   = 360;

    typedef enum logic [2:0] {
        TAG_NONE   = 3'd0,
        TAG_DUMMY  = 3'd1,
        TAG_BLACK  = 3'd2,
        TAG_TIMING = 3'd3,
        TAG_ACTIVE = 3'd4
    } pix_tag_e;

    typedef struct packed {
        logic [2:0] rclk;
        logic       sg;
        logic       rg;
    } hdrive_s;

    // high for three sub-ticks starting at 'first', wrapping modulo SUBS
    function automatic logic phase_hi(input logic [SUB_W-1:0] sub, input int first);
        int d;
        d = (int'(sub) + SUBS - first) % SUBS;
        return d < SUBS / 2;
    endfunction

endpackage

// File: rtl/ccd_hline_seq.sv
module ccd_hline_seq
    import ccd_hline_pkg::*;
#(
    parameter int LINE_LEN  = 3487,
    parameter int SHIFT_LEN = 3127,
    parameter int PIX_W     = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_start,
    input  logic             bin_en,
    output logic             busy,
    output logic             shifting,
    output logic             bin_q,
    output logic [PIX_W-1:0] pix,
    output logic [SUB_W-1:0] sub,
    output logic             last
);

    localparam logic [PIX_W-1:0] PIX_LAST = PIX_W'(LINE_LEN - 1);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUBS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            bin_q <= 1'b0;
            pix   <= '0;
            sub   <= '0;
        end else if (!busy) begin
            pix <= '0;
            sub <= '0;
            if (line_start) begin
                busy  <= 1'b1;
                bin_q <= bin_en;
            end
        end else if (sub == SUB_LAST) begin
            sub <= '0;
            if (pix == PIX_LAST) begin
                busy <= 1'b0;
                pix  <= '0;
            end else begin
                pix <= pix + 1'b1;
            end
        end else begin
            sub <= sub + 1'b1;
        end
    end

    assign shifting = busy && (int'(pix) < SHIFT_LEN);
    assign last     = busy && (pix == PIX_LAST) && (sub == SUB_LAST);

    // R2
    done_ends_line_chk: assert property (@(posedge clk) disable iff (rst)
        last |=> !busy);

    // R3
    line_runs_through_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !last |=> busy);

endmodule

// File: rtl/ccd_hline_phase.sv
module ccd_hline_phase
    import ccd_hline_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             shifting,
    input  logic             bin_q,
    input  logic             pix_odd,
    input  logic [SUB_W-1:0] sub,
    output hdrive_s          drv
);

    // three phases, each starting two sub-ticks (120 degrees) after the last
    for (genvar i = 0; i < 3; i++) begin : g_phase
        assign drv.rclk[i] = shifting && phase_hi(sub, 2 * i);
    end

    logic first_half;
    assign first_half = int'(sub) < SUBS / 2;

    always_comb begin
        drv.sg = 1'b0;
        drv.rg = 1'b0;
        if (shifting) begin
            if (bin_q) begin
                drv.sg = !pix_odd || first_half;
                drv.rg = !pix_odd && (sub == '0);
            end else begin
                drv.sg = first_half;
                drv.rg = (sub == '0);
            end
        end
    end

    // R5
    c2_rises_under_c1_chk: assert property (@(posedge clk) disable iff (rst)
        shifting && $rose(drv.rclk[1]) |-> drv.rclk[0]);

    // R6
    rg_one_tick_chk: assert property (@(posedge clk) disable iff (rst)
        drv.rg |=> !drv.rg);

    // R11
    rg_binned_even_chk: assert property (@(posedge clk) disable iff (rst)
        drv.rg && bin_q |-> !pix_odd);

endmodule

// File: rtl/ccd_hline_class.sv
module ccd_hline_class
    import ccd_hline_pkg::*;
#(
    parameter int N_DUMMY  = DEF_DUMMY,
    parameter int N_BLACK  = DEF_BLACK,
    parameter int N_TIMING = DEF_TIMING,
    parameter int N_ACTIVE = DEF_ACTIVE,
    parameter int PIX_W    = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shifting,
    input  logic             bin_q,
    input  logic [PIX_W-1:0] pix,
    input  logic [SUB_W-1:0] sub,
    output pix_tag_e         tag,
    output logic             clamp,
    output logic             sample_valid
);

    localparam int END_DUMMY = N_DUMMY;
    localparam int END_BLK1  = END_DUMMY + N_BLACK;
    localparam int END_TIM1  = END_BLK1 + N_TIMING;
    localparam int END_ACT   = END_TIM1 + N_ACTIVE;
    localparam int END_TIM2  = END_ACT + N_TIMING;
    localparam int END_BLK2  = END_TIM2 + N_BLACK;

    logic [SUB_W-1:0] sub_last;
    int p;
    assign sub_last = SUB_W'(SUBS - 1);
    assign p = int'(pix);

    always_comb begin
        tag = TAG_NONE;
        if (shifting) begin
            if (p < END_DUMMY)     tag = TAG_DUMMY;
            else if (p < END_BLK1) tag = TAG_BLACK;
            else if (p < END_TIM1) tag = TAG_TIMING;
            else if (p < END_ACT)  tag = TAG_ACTIVE;
            else if (p < END_TIM2) tag = TAG_TIMING;
            else if (p < END_BLK2) tag = TAG_BLACK;
        end
    end

    assign clamp        = shifting && (p >= END_TIM2) && (p < END_BLK2);
    assign sample_valid = shifting && (sub == sub_last) && (!bin_q || pix[0]);

    // R10
    valid_has_tag_chk: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> tag != TAG_NONE);

    // R9
    clamp_on_black_chk: assert property (@(posedge clk) disable iff (rst)
        clamp |-> tag == TAG_BLACK);

endmodule

// File: rtl/ccd_hline_timing.sv
module ccd_hline_timing
    import ccd_hline_pkg::*;
#(
    parameter int N_DUMMY  = DEF_DUMMY,
    parameter int N_BLACK  = DEF_BLACK,
    parameter int N_TIMING = DEF_TIMING,
    parameter int N_ACTIVE = DEF_ACTIVE,
    parameter int N_STOP   = DEF_STOP
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_start,
    input  logic       bin_en,
    output logic       reg_c1,
    output logic       reg_c2,
    output logic       reg_c3,
    output logic       sum_gate,
    output logic       reset_gate,
    output logic       shift_en,
    output logic [2:0] pix_tag,
    output logic       clamp_win,
    output logic       sample_valid,
    output logic       line_done
);

    localparam int SHIFT_LEN = N_DUMMY + 2 * N_BLACK + 2 * N_TIMING + N_ACTIVE;
    localparam int LINE_LEN  = SHIFT_LEN + N_STOP;
    localparam int PIX_W     = $clog2(LINE_LEN);

    logic             busy, shifting, bin_q, last;
    logic [PIX_W-1:0] pix;
    logic [SUB_W-1:0] sub;
    hdrive_s          drv;
    pix_tag_e         tag;

    ccd_hline_seq #(
        .LINE_LEN (LINE_LEN),
        .SHIFT_LEN(SHIFT_LEN),
        .PIX_W    (PIX_W)
    ) seq_i (
        .clk       (clk),
        .rst       (rst),
        .line_start(line_start),
        .bin_en    (bin_en),
        .busy      (busy),
        .shifting  (shifting),
        .bin_q     (bin_q),
        .pix       (pix),
        .sub       (sub),
        .last      (last)
    );

    ccd_hline_phase phase_i (
        .clk     (clk),
        .rst     (rst),
        .shifting(shifting),
        .bin_q   (bin_q),
        .pix_odd (pix[0]),
        .sub     (sub),
        .drv     (drv)
    );

    ccd_hline_class #(
        .N_DUMMY (N_DUMMY),
        .N_BLACK (N_BLACK),
        .N_TIMING(N_TIMING),
        .N_ACTIVE(N_ACTIVE),
        .PIX_W   (PIX_W)
    ) class_i (
        .clk         (clk),
        .rst         (rst),
        .shifting    (shifting),
        .bin_q       (bin_q),
        .pix         (pix),
        .sub         (sub),
        .tag         (tag),
        .clamp       (clamp_win),
        .sample_valid(sample_valid)
    );

    assign reg_c1     = drv.rclk[0];
    assign reg_c2     = drv.rclk[1];
    assign reg_c3     = drv.rclk[2];
    assign sum_gate   = drv.sg;
    assign reset_gate = drv.rg;
    assign shift_en   = shifting;
    assign pix_tag    = tag;
    assign line_done  = last;

    // R4
    stopped_clocks_chk: assert property (@(posedge clk) disable iff (rst)
        !shift_en |-> !(reg_c1 || reg_c2 || reg_c3 || sum_gate || reset_gate));

    // R2
    done_outside_shift_chk: assert property (@(posedge clk) disable iff (rst)
        line_done |-> !shift_en && busy);

endmodule

// File: tb/ccd_hline_timing_tb_top.sv
module ccd_hline_timing_tb_top;

    localparam int SHIFT = 3127;
    localparam int LINE  = 3487;
    localparam int CYC   = LINE * 6;
    localparam int IDLE  = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_start = 1'b0;
    logic bin_en = 1'b0;
    logic reg_c1, reg_c2, reg_c3, sum_gate, reset_gate, shift_en;
    logic [2:0] pix_tag;
    logic clamp_win, sample_valid, line_done;

    int checks = 0;
    int fails = 0;
    int act_samples = 0;
    logic [11:0] exp_q[$];

    always #5 clk = ~clk;

    ccd_hline_timing dut_i (
        .clk(clk), .rst(rst), .line_start(line_start), .bin_en(bin_en),
        .reg_c1(reg_c1), .reg_c2(reg_c2), .reg_c3(reg_c3),
        .sum_gate(sum_gate), .reset_gate(reset_gate), .shift_en(shift_en),
        .pix_tag(pix_tag), .clamp_win(clamp_win),
        .sample_valid(sample_valid), .line_done(line_done)
    );

    // packing: {c1,c2,c3,sg,rg,shift,tag[2:0],clamp,valid,done}
    function automatic logic [11:0] expect_at(int k, bit bin);
        int p = k / 6;
        int s = k % 6;
        bit sh = (k < CYC) && (p < SHIFT);
        logic [2:0] t = 3'd0;
        logic c1, c2, c3, sg, rg, cl, vl, dn;
        c1 = sh && (s <= 2);
        c2 = sh && (s >= 2) && (s <= 4);
        c3 = sh && (s >= 4 || s == 0);
        sg = sh && (bin ? ((p % 2 == 0) || s < 3) : s < 3);
        rg = sh && (s == 0) && (!bin || p % 2 == 0);
        vl = sh && (s == 5) && (!bin || p % 2 == 1);
        cl = sh && (p >= 3107);
        dn = (p == LINE - 1) && (s == 5);
        if (sh) begin
            if (p < 7)         t = 3'd1;
            else if (p < 27)   t = 3'd2;
            else if (p < 31)   t = 3'd3;
            else if (p < 3103) t = 3'd4;
            else if (p < 3107) t = 3'd3;
            else               t = 3'd2;
        end
        return {c1, c2, c3, sg, rg, sh, t, cl, vl, dn};
    endfunction

    function automatic logic [11:0] observed();
        return {reg_c1, reg_c2, reg_c3, sum_gate, reset_gate, shift_en,
                pix_tag, clamp_win, sample_valid, line_done};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    // monitor: pops expected items and compares field groups
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [11:0] e, a;
                e = exp_q.pop_front();
                a = observed();
                if (sample_valid === 1'b1 && pix_tag === 3'd4) act_samples++;
                checks++;
                if (a !== e) begin
                    fails++;
                    if (a[11:9] !== e[11:9]) $display("FAIL R5 clocks: actual %b expected %b", a[11:9], e[11:9]);
                    if (a[8] !== e[8])   $display("FAIL R7/R11 sum_gate: actual %b expected %b", a[8], e[8]);
                    if (a[7] !== e[7])   $display("FAIL R6/R11 reset_gate: actual %b expected %b", a[7], e[7]);
                    if (a[6] !== e[6])   $display("FAIL R4 shift_en: actual %b expected %b", a[6], e[6]);
                    if (a[5:3] !== e[5:3]) $display("FAIL R8 tag: actual %0d expected %0d", a[5:3], e[5:3]);
                    if (a[2] !== e[2])   $display("FAIL R9 clamp: actual %b expected %b", a[2], e[2]);
                    if (a[1] !== e[1])   $display("FAIL R10/R11 valid: actual %b expected %b", a[1], e[1]);
                    if (a[0] !== e[0])   $display("FAIL R2 line_done: actual %b expected %b", a[0], e[0]);
                end
            end
        end
    end

    // driver: starts a line, pushes the whole expected line, then
    // disturbs it with a stray start (R3) and a bin_en flip (R12)
    task automatic run_line(bit bin);
        @(negedge clk);
        bin_en = bin;
        line_start = 1'b1;
        @(posedge clk);
        for (int k = 0; k < CYC + IDLE; k++) exp_q.push_back(expect_at(k, bin));
        for (int k = 0; k < CYC + IDLE; k++) begin
            @(negedge clk);
            line_start = (k == 600) || (k == CYC - 40);
            if (k == 900) bin_en = !bin;
        end
        line_start = 1'b0;
        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        #1;
        // R1 outputs during reset
        check("R1", {20'd0, observed()}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        // R1 idle after reset
        check("R1", {20'd0, observed()}, 32'd0);

        // R5 R6 R7 R8 R9 R10 unbinned line with disturbances (R3 R12)
        act_samples = 0;
        run_line(1'b0);
        check("R10", act_samples, 3072);

        // R11 binned line, bin_en flipped mid-line (R12)
        act_samples = 0;
        run_line(1'b1);
        check("R11", act_samples, 1536);

        // R1 reset in the middle of a line returns to idle
        @(negedge clk);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        repeat (50) @(negedge clk);
        #1;
        check("R4", {31'd0, shift_en}, 32'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check("R1", {20'd0, observed()}, 32'd0);

        // R2 a fresh start right after reset begins at pixel 0 sub 0
        @(negedge clk);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        #1;
        check("R2", {20'd0, observed()}, {20'd0, expect_at(0, 1'b0)});
        @(negedge clk);
        #1;
        check("R2", {20'd0, observed()}, {20'd0, expect_at(1, 1'b0)});

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule